// File: doc/BRIEF.md
# Multi-Pin Output Compare Unit with Software Force

This block is the output-compare section of a general-purpose timer. A 16-bit counter runs freely, one step per clock. Five compare channels each hold a 16-bit compare value. When the count equals a channel's compare value, the channel raises its status flag and performs a pin action. Channel 0 is the master channel. It does not drive one fixed pin. On its event it drives every pin that its mask selects to the level that its data word gives, so one comparison can shape several outputs at once. Channels 1 to 4 each drive their own pin (pin k) through a 2-bit action code.

Software sets the block up through a simple word-wide register port with two byte lanes. A force register lets software fire any set of channels at once. A forced channel does exactly what a real match would do to the pins, but it leaves the status flags untouched. The force byte shares a 16-bit word with a neighbouring 8-bit field that belongs to another function. That neighbour byte is kept here only as a plain holding byte. Each pin reaches the outside only when its direction bit marks it as an output.

Register map (word addresses): 0 to 4 hold the compare value of channels 0 to 4; 5 holds the master mask and data; 6 holds the action codes; 7 holds the force byte and the neighbour byte; 8 holds the direction bits; 9 holds the status flags.

Top module: `ocf_unit`

## Requirements
- R1: `tcnt` is 0 while reset is held. It then rises by exactly one per clock and wraps from 16'hFFFF to 0.
- R2: A channel's flag (address 9, bit k for channel k; also on `flags`) sets at the end of the clock cycle in which `tcnt` equals that channel's compare value (address k). Several channels may set their flags in the same cycle. Writing 1 to a flag bit with the low lane enabled clears it. If a set and a clear fall in the same cycle, the set wins.
- R3: Channel k (k = 1 to 4) takes its action code from address 6, bits [2k-1:2k-2]. The codes are: 00 leaves the pin unchanged, 01 toggles it, 10 drives it to 0, 11 drives it to 1. The pin changes at the clock edge that ends the matching cycle. A pin with no event keeps its level.
- R4: The master mask is address 5, bits [4:0], and the master data is address 5, bits [12:8]. On a master event, every pin i whose mask bit is 1 takes data bit i, all at the same edge. Pins whose mask bit is 0 are left alone by the master.
- R5: When the master and channel k both act on pin k at the same edge, pin k takes the master's data level.
- R6: `pin_oe` equals the direction bits (address 8, bits [4:0]). `pin_out[i]` is the internal pin level when direction bit i is 1 and is 0 otherwise. The internal level is kept while the pin is an input.
- R7: If the master sets a pin at count T and that pin's own channel clears it at count T+1, the pin is high for exactly one clock.
- R8: A write to address 7 with the high lane enabled fires each channel k whose bit 8+k is 1. The pins change at the edge of that write, as they would on a match. No flag is set.
- R9: Address 7 bits [15:8] always read 0. Bits [7:0] are a holding byte that only a low-lane write changes. A write with only the low lane enabled forces nothing.
- R10: While reset is held, `pin_out`, `pin_oe` and `flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_be | input | 2 | Byte lanes: bit 0 selects [7:0], bit 1 selects [15:8] |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| tcnt | output | 16 | Free-running timer count |
| pin_out | output | 5 | Compare output pin levels |
| pin_oe | output | 5 | Pin output enables |
| flags | output | 5 | Per-channel compare status flags |

## Verification
The bench fires the master and a normal channel at the same count, each asking for a different level on the same pin. A design that let the normal channel win would leave the pin high. Master and channel 1 are set one count apart so the pin should be high for exactly one clock. A wrong edge or a wrong priority shows up as a pulse of zero or two clocks. The force word is written with the high lane only, the low lane only, and both lanes. A design that decoded the lanes wrongly would fire on a low-lane write, clobber the neighbour byte, or set a flag on a forced event. The bench also clears a direction bit to check that the internal level still survives while the pin is gated off.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;
endpackage

// File: rtl/ocf_timer.sv
module ocf_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] cnt_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) + TW'(1)));
endmodule

// File: rtl/ocf_regs.sv
module ocf_regs #(
    parameter int NCH = 5,
    parameter int TW  = 16,
    parameter int AW  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [1:0]             wr_be,
    input  logic [15:0]            wr_data,
    input  logic [AW-1:0]          rd_addr,
    input  logic [NCH-1:0]         flags_i,
    output logic [15:0]            rd_data,
    output logic [NCH-1:0][TW-1:0] cmp_o,
    output logic [NCH-1:0]         mask_o,
    output logic [NCH-1:0]         data_o,
    output logic [2*(NCH-1)-1:0]   act_o,
    output logic [NCH-1:0]         dir_o,
    output logic [NCH-1:0]         force_o,
    output logic [NCH-1:0]         flag_clr_o
);
    localparam int A_MASK  = NCH;
    localparam int A_ACT   = NCH + 1;
    localparam int A_FORCE = NCH + 2;
    localparam int A_DIR   = NCH + 3;
    localparam int A_FLAG  = NCH + 4;
    localparam int ACTW    = 2 * (NCH - 1);

    typedef struct packed {
        logic [NCH-1:0][TW-1:0] cmp;
        logic [NCH-1:0]         mask;
        logic [NCH-1:0]         data;
        logic [ACTW-1:0]        act;
        logic [NCH-1:0]         dir;
        logic [7:0]             aux;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int k = 0; k < NCH; k++) begin
                if (wr_addr == AW'(k)) begin
                    for (int b = 0; b < TW; b++)
                        if (wr_be[b/8]) st_d.cmp[k][b] = wr_data[b];
                end
            end
            if (wr_addr == AW'(A_MASK)) begin
                if (wr_be[0]) st_d.mask = wr_data[NCH-1:0];
                if (wr_be[1]) st_d.data = wr_data[8 +: NCH];
            end
            if (wr_addr == AW'(A_ACT)) begin
                for (int b = 0; b < ACTW; b++)
                    if (wr_be[b/8]) st_d.act[b] = wr_data[b];
            end
            if (wr_addr == AW'(A_FORCE) && wr_be[0]) st_d.aux = wr_data[7:0];
            if (wr_addr == AW'(A_DIR) && wr_be[0])   st_d.dir = wr_data[NCH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        force_o    = '0;
        flag_clr_o = '0;
        if (wr_en && wr_addr == AW'(A_FORCE) && wr_be[1]) force_o    = wr_data[8 +: NCH];
        if (wr_en && wr_addr == AW'(A_FLAG) && wr_be[0])  flag_clr_o = wr_data[NCH-1:0];
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NCH; k++)
            if (rd_addr == AW'(k)) rd_data = 16'(st_q.cmp[k]);
        if (rd_addr == AW'(A_MASK)) begin
            rd_data[NCH-1:0]  = st_q.mask;
            rd_data[8 +: NCH] = st_q.data;
        end
        if (rd_addr == AW'(A_ACT))   rd_data = 16'(st_q.act);
        if (rd_addr == AW'(A_FORCE)) rd_data = {8'h00, st_q.aux};
        if (rd_addr == AW'(A_DIR))   rd_data = 16'(st_q.dir);
        if (rd_addr == AW'(A_FLAG))  rd_data = 16'(flags_i);
    end

    assign cmp_o  = st_q.cmp;
    assign mask_o = st_q.mask;
    assign data_o = st_q.data;
    assign act_o  = st_q.act;
    assign dir_o  = st_q.dir;

    p_aux_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(A_FORCE) && !wr_be[0]) |=> $stable(st_q.aux));
endmodule

// File: rtl/ocf_pins.sv
module ocf_pins
    import ocf_pkg::*;
#(
    parameter int NCH = 5,
    parameter int TW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TW-1:0]          cnt_i,
    input  logic [NCH-1:0][TW-1:0] cmp_i,
    input  logic [NCH-1:0]         mask_i,
    input  logic [NCH-1:0]         data_i,
    input  logic [2*(NCH-1)-1:0]   act_i,
    input  logic [NCH-1:0]         force_i,
    input  logic [NCH-1:0]         clr_i,
    output logic [NCH-1:0]         level_o,
    output logic [NCH-1:0]         flags_o
);
    typedef struct packed {
        logic [NCH-1:0] out;
        logic [NCH-1:0] flg;
    } pin_t;

    pin_t st_d, st_q;
    logic [NCH-1:0]   match;
    logic [NCH-1:0]   ev;
    logic [2*NCH-1:0] act_all;

    always_comb begin
        for (int i = 0; i < NCH; i++) match[i] = (cnt_i == cmp_i[i]);
        ev      = match | force_i;
        act_all = {act_i, 2'b00};
        st_d    = st_q;
        for (int i = 0; i < NCH; i++) begin
            if (ev[i]) begin
                unique case (act_e'(act_all[2*i +: 2]))
                    ACT_TOGGLE: st_d.out[i] = ~st_q.out[i];
                    ACT_CLEAR:  st_d.out[i] = 1'b0;
                    ACT_SET:    st_d.out[i] = 1'b1;
                    default:    st_d.out[i] = st_q.out[i];
                endcase
            end
            if (ev[0] && mask_i[i]) st_d.out[i] = data_i[i];
        end
        st_d.flg = (st_q.flg & ~clr_i) | match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.out;
    assign flags_o = st_q.flg;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_master_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[0] && mask_i[g]) |=> (st_q.out[g] == $past(data_i[g])));
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev[g] && !(ev[0] && mask_i[g])) |=> (st_q.out[g] == $past(st_q.out[g])));
        p_no_force_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!st_q.flg[g] && !match[g]) |=> !st_q.flg[g]);
        p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !match[g]) |=> !st_q.flg[g]);
    end
endmodule

// File: rtl/ocf_unit.sv
module ocf_unit #(
    parameter int NCH = 5,
    parameter int TW  = 16,
    parameter int AW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [1:0]     wr_be,
    input  logic [15:0]    wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [15:0]    rd_data,
    output logic [TW-1:0]  tcnt,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe,
    output logic [NCH-1:0] flags
);
    logic [NCH-1:0][TW-1:0] cmp;
    logic [NCH-1:0]         mask, data, dir, frc, clr, level;
    logic [2*(NCH-1)-1:0]   act;

    ocf_timer #(.TW(TW)) timer_i (
        .clk(clk), .rst_n(rst_n), .cnt_o(tcnt)
    );

    ocf_regs #(.NCH(NCH), .TW(TW), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .rd_addr(rd_addr),
        .flags_i(flags), .rd_data(rd_data), .cmp_o(cmp), .mask_o(mask),
        .data_o(data), .act_o(act), .dir_o(dir), .force_o(frc),
        .flag_clr_o(clr)
    );

    ocf_pins #(.NCH(NCH), .TW(TW)) pins_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(tcnt), .cmp_i(cmp),
        .mask_i(mask), .data_i(data), .act_i(act), .force_i(frc),
        .clr_i(clr), .level_o(level), .flags_o(flags)
    );

    assign pin_oe  = dir;
    assign pin_out = level & dir;
endmodule

// File: tb/ocf_unit_tb.sv
module ocf_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [1:0]  wr_be = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] tcnt;
    logic [4:0]  pin_out, pin_oe, flags;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ocf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .tcnt(tcnt), .pin_out(pin_out),
        .pin_oe(pin_oe), .flags(flags)
    );

    // vector: [7:5] channel, [4:3] action code, [2] level before, [1] level after
    localparam logic [7:0] VEC [8] = '{
        {3'd1, 2'b01, 1'b0, 1'b1, 1'b0},
        {3'd1, 2'b01, 1'b1, 1'b0, 1'b0},
        {3'd2, 2'b10, 1'b1, 1'b0, 1'b0},
        {3'd2, 2'b11, 1'b0, 1'b1, 1'b0},
        {3'd3, 2'b00, 1'b1, 1'b1, 1'b0},
        {3'd4, 2'b11, 1'b0, 1'b1, 1'b0},
        {3'd4, 2'b10, 1'b1, 1'b0, 1'b0},
        {3'd3, 2'b01, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_cnt(input logic [15:0] t);
        while (tcnt != t) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] r, t;
        int ch;
        // R10 / R1: reset state
        @(negedge clk); @(negedge clk);
        chk("R1 reset count", tcnt, 16'h0000);
        chk("R10 reset pins", 16'(pin_out), 16'h0000);
        chk("R10 reset oe", 16'(pin_oe), 16'h0000);
        chk("R10 reset flags", 16'(flags), 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        t = tcnt;
        @(negedge clk);
        chk("R1 step", tcnt, t + 16'd1);

        wr(4'd8, 16'h001F, 2'b01);
        chk("R6 oe", 16'(pin_oe), 16'h001F);
        wr(4'd9, 16'h001F, 2'b01);
        chk("R2 clear", 16'(flags), 16'h0000);

        // R3 / R8: action codes via force, walked from the table
        for (int v = 0; v < 8; v++) begin
            ch = int'(VEC[v][7:5]);
            wr(4'd5, (16'(VEC[v][2]) << (8 + ch)) | (16'h1 << ch), 2'b11);
            wr(4'd7, 16'h0100, 2'b10);
            wr(4'd6, 16'(VEC[v][4:3]) << (2 * (ch - 1)), 2'b01);
            wr(4'd7, 16'h1 << (8 + ch), 2'b10);
            chk("R3 action", 16'(pin_out[ch]), 16'(VEC[v][1]));
            chk("R8 no flag on force", 16'(flags), 16'h0000);
        end
        wr(4'd6, 16'h0000, 2'b01);

        // R4 / R2: master match drives several pins at once
        wr(4'd5, 16'h0A1F, 2'b11);
        t = tcnt + 16'd20;
        wr(4'd0, t, 2'b11);
        wait_cnt(t);
        @(negedge clk);
        chk("R4 multi-pin", 16'(pin_out), 16'h000A);
        chk("R2 flag set", 16'(flags), 16'h0001);
        wr(4'd9, 16'h0001, 2'b01);
        chk("R2 w1c", 16'(flags), 16'h0000);

        // R5: master and channel 2 collide on pin 2
        wr(4'd6, 16'h000C, 2'b01);
        wr(4'd5, 16'h0004, 2'b11);
        t = tcnt + 16'd20;
        wr(4'd0, t, 2'b11);
        wr(4'd2, t, 2'b11);
        wait_cnt(t);
        @(negedge clk);
        chk("R5 master wins", 16'(pin_out[2]), 16'h0000);
        chk("R2 two flags", 16'(flags), 16'h0005);
        wr(4'd9, 16'h001F, 2'b01);

        // R7: one-count pulse on pin 1
        wr(4'd5, 16'h0002, 2'b11);
        wr(4'd7, 16'h0100, 2'b10);
        wr(4'd5, 16'h0202, 2'b11);
        wr(4'd6, 16'h0002, 2'b01);
        t = tcnt + 16'd20;
        wr(4'd0, t, 2'b11);
        wr(4'd1, t + 16'd1, 2'b11);
        wait_cnt(t);
        chk("R7 before", 16'(pin_out[1]), 16'h0000);
        @(negedge clk);
        chk("R7 high", 16'(pin_out[1]), 16'h0001);
        @(negedge clk);
        chk("R7 low again", 16'(pin_out[1]), 16'h0000);

        // R6: gating by direction, level kept
        wr(4'd8, 16'h0017, 2'b01);
        chk("R6 gated", 16'(pin_out[3]), 16'h0000);
        chk("R6 oe value", 16'(pin_oe), 16'h0017);
        wr(4'd8, 16'h001F, 2'b01);
        chk("R6 level kept", 16'(pin_out[3]), 16'h0001);

        // R8 / R9: byte-lane behaviour of the force word
        wr(4'd9, 16'h001F, 2'b01);
        wr(4'd6, 16'h0040, 2'b01);
        wr(4'd7, 16'h10A5, 2'b01);
        chk("R9 low lane no force", 16'(pin_out[4]), 16'h0000);
        rd(4'd7, r);
        chk("R9 hold byte", r, 16'h00A5);
        wr(4'd7, 16'h1000, 2'b10);
        chk("R8 byte force", 16'(pin_out[4]), 16'h0001);
        chk("R8 flags clean", 16'(flags), 16'h0000);
        rd(4'd7, r);
        chk("R9 read zero, byte kept", r, 16'h00A5);
        wr(4'd7, 16'h105A, 2'b11);
        chk("R8 word force", 16'(pin_out[4]), 16'h0000);
        rd(4'd7, r);
        chk("R9 word write", r, 16'h005A);

        // R1: wrap
        wait_cnt(16'hFFFF);
        @(negedge clk);
        chk("R1 wrap", tcnt, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule